// File: doc/BRIEF.md
# DC-Only Block Reconstruction Adder

This block rebuilds a block of pixels when the only nonzero residual coefficient is the DC term. It does not run an inverse transform. It turns the DC coefficient into one rounded offset, adds that offset to every prediction pixel of the block, and saturates each sum to the 10-bit pixel range. It then writes the row back to the same place.

A command arrives on a one-cycle `start` strobe. The strobe carries:
- one or two 32-bit DC values,
- a block shape,
- a base row address,
- a row stride.

The block streams rows out of a pixel store that has one cycle of read latency. Each store word holds eight pixels. The block handles one row per cycle and writes the reconstructed row two cycles after it issued the read. A strobe, `clr_en`, tells the coefficient store to zero the DC values it has used. `busy` is high for the whole command, and `done` marks the final write.

There are three block shapes:
- a single 4x4 block, using the low four lanes;
- a horizontally adjacent pair of 4x4 blocks, where each half of the row uses its own DC value;
- an 8x8 block with one DC value across all eight lanes.

Top module: `dc_recon_adder`

## Requirements
- R1: The offset applied to a pixel is floor((DC + 32) / 2^6), an arithmetic right shift by 6 of the DC plus 32, computed without overflow for every 32-bit signed DC.
- R2: Each written pixel equals prediction + offset, saturated to 0..1023. A large negative offset gives 0 and never wraps; a large positive offset gives 1023.
- R3: `blk_mode` encoding and lane usage:
  - 2'b00: one 4x4 block. It uses 4 rows, lanes 0..3, `wr_mask` 8'h0F, and `dc_a`.
  - 2'b01: two 4x4 blocks. It uses 4 rows and `wr_mask` 8'hFF. Lanes 0..3 use `dc_a` and lanes 4..7 use `dc_b`.
  - 2'b1x: one 8x8 block. It uses 8 rows, `wr_mask` 8'hFF, and `dc_a` on all lanes.
  - Lane i of a row occupies bits [10*i+9 : 10*i].
- R4: Row r (r = 0, 1, ...) is read at address `base_addr + r*stride`, modulo 2^10. Rows are read in increasing r, one per cycle, on consecutive cycles.
- R5: In the cycle after a command is accepted, `clr_en` is high for exactly one cycle. `clr_sel` is then 2'b11 in pair mode and 2'b01 otherwise. It is not raised at any other time.
- R6: The pixel store returns `rd_data` one cycle after a cycle with `rd_en` high. The write of that row appears on `wr_en`/`wr_addr`/`wr_data` one cycle later, at the address that was read.
- R7: A command is accepted on a rising clock edge where `start` is high and `busy` is low. With N rows, `done` is high for one cycle, N+1 edges after that edge, together with the last write. `busy` is high from the accepting edge through the `done` cycle and low after it.
- R8: A `start` that arrives while `busy` is high is ignored. It causes no writes, no extra `clr_en`, and no change to the command in progress.
- R9: Rows outside the block and lanes outside `wr_mask` are left unchanged in the pixel store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| blk_mode | input | 2 | Block shape: 00 single 4x4, 01 pair of 4x4, 1x 8x8 |
| dc_a | input | 32 | DC coefficient for the whole block, or for the left half in pair mode (two's complement) |
| dc_b | input | 32 | DC coefficient for the right half in pair mode |
| base_addr | input | 10 | Address of row 0 |
| stride | input | 10 | Address step between rows |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse with the final row write |
| rd_en | output | 1 | Row read request |
| rd_addr | output | 10 | Row read address |
| rd_data | input | 80 | Prediction row, 8 lanes of 10 bits, valid one cycle after `rd_en` |
| wr_en | output | 1 | Row write strobe |
| wr_addr | output | 10 | Row write address |
| wr_data | output | 80 | Reconstructed row, 8 lanes of 10 bits |
| wr_mask | output | 8 | Per-lane write enable |
| clr_en | output | 1 | Strobe asking the coefficient store to zero the consumed DC |
| clr_sel | output | 2 | Which DC to zero: bit 0 for `dc_a`, bit 1 for `dc_b` |

## Verification
The assertions assume the pixel store answers a read in exactly one cycle, and that `start` is low throughout reset. The stride and base are kept small enough that the rows of a block never alias one another. The bench drives only these shapes of stimulus: a memory model with a one-cycle registered read, bases 0..15 with strides 1..6, and `start` driven away from the clock edge. It also drives extra `start` pulses while a command is running, because that is the condition on which the ignore property depends.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  typedef enum logic [1:0] {
    SHAPE_SINGLE = 2'b00,
    SHAPE_PAIR   = 2'b01,
    SHAPE_LARGE  = 2'b10,
    SHAPE_LARGE2 = 2'b11
  } shape_e;

  function automatic logic shape_is_large(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic shape_is_pair(input logic [1:0] m);
    return (m == SHAPE_PAIR);
  endfunction

endpackage

// File: rtl/dcr_offset.sv
module dcr_offset #(
  parameter int DC_W  = 32,
  parameter int OFF_W = 12,
  parameter int SHIFT = 6
) (
  input  logic [DC_W-1:0]         dc,
  output logic signed [OFF_W-1:0] off
);
  localparam int RND = 1 << (SHIFT - 1);
  localparam longint HI_L = (longint'(1) << (OFF_W - 1)) - 1;
  localparam longint LO_L = -(longint'(1) << (OFF_W - 1));
  localparam logic signed [DC_W:0] HI = (DC_W+1)'(HI_L);
  localparam logic signed [DC_W:0] LO = (DC_W+1)'(LO_L);

  logic signed [DC_W:0] sum;
  logic signed [DC_W:0] shd;

  // One guard bit keeps the rounding add exact for every DC value.
  always_comb begin
    sum = $signed({dc[DC_W-1], dc}) + $signed((DC_W+1)'(RND));
    shd = sum >>> SHIFT;
    if (shd > HI)      off = HI[OFF_W-1:0];
    else if (shd < LO) off = LO[OFF_W-1:0];
    else               off = shd[OFF_W-1:0];
  end
endmodule

// File: rtl/dcr_lane_clip.sv
module dcr_lane_clip #(
  parameter int PIX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [PIX_W-1:0]        pred,
  input  logic signed [OFF_W-1:0] off,
  output logic [PIX_W-1:0]        pix
);
  localparam int SUM_W = OFF_W + 1;
  localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = $signed({{(SUM_W-PIX_W){1'b0}}, pred}) + $signed({off[OFF_W-1], off});
    if (sum[SUM_W-1])  pix = '0;
    else if (sum > PMAX) pix = '1;
    else               pix = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/dcr_row_seq.sv
module dcr_row_seq #(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  input  logic [ROW_W-1:0]  rows_m1,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_last
);
  logic [ROW_W-1:0]  row_q;
  logic [ROW_W-1:0]  last_q;
  logic [ADDR_W-1:0] next_q;
  logic [ADDR_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en   <= 1'b0;
      rd_addr <= '0;
      row_q   <= '0;
      last_q  <= '0;
      next_q  <= '0;
      step_q  <= '0;
    end else if (accept) begin
      rd_en   <= 1'b1;
      rd_addr <= base;
      row_q   <= '0;
      last_q  <= rows_m1;
      next_q  <= base + step;
      step_q  <= step;
    end else if (rd_en) begin
      if (row_q == last_q) begin
        rd_en <= 1'b0;
      end else begin
        row_q   <= row_q + 1'b1;
        rd_addr <= next_q;
        next_q  <= next_q + step_q;
      end
    end
  end

  assign rd_last = rd_en && (row_q == last_q);
endmodule

// File: rtl/dc_recon_adder.sv
module dc_recon_adder #(
  parameter int LANES  = 8,
  parameter int PIX_W  = 10,
  parameter int DC_W   = 32,
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               blk_mode,
  input  logic [DC_W-1:0]          dc_a,
  input  logic [DC_W-1:0]          dc_b,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [ADDR_W-1:0]        stride,
  output logic                     busy,
  output logic                     done,
  output logic                     rd_en,
  output logic [ADDR_W-1:0]        rd_addr,
  input  logic [LANES*PIX_W-1:0]   rd_data,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [LANES*PIX_W-1:0]   wr_data,
  output logic [LANES-1:0]         wr_mask,
  output logic                     clr_en,
  output logic [1:0]               clr_sel
);
  import dcr_pkg::*;

  localparam int HALF  = LANES / 2;
  localparam int ROW_W = $clog2(LANES);
  localparam int OFF_W = PIX_W + 2;
  localparam logic [LANES-1:0] MASK_LO = LANES'((1 << HALF) - 1);

  logic                    accept;
  logic signed [OFF_W-1:0] off_a_c, off_b_c;
  logic signed [OFF_W-1:0] off_a_q, off_b_q;
  logic                    pair_q, large_q;
  logic [ROW_W-1:0]        rows_m1;
  logic                    rd_last;
  logic                    s1_valid, s1_last;
  logic [ADDR_W-1:0]       s1_addr;
  logic [LANES*PIX_W-1:0]  row_out;

  assign accept  = start && !busy;
  assign rows_m1 = shape_is_large(blk_mode) ? ROW_W'(LANES - 1) : ROW_W'(HALF - 1);

  dcr_offset #(.DC_W(DC_W), .OFF_W(OFF_W), .SHIFT(6)) u_off_a (.dc(dc_a), .off(off_a_c));
  dcr_offset #(.DC_W(DC_W), .OFF_W(OFF_W), .SHIFT(6)) u_off_b (.dc(dc_b), .off(off_b_c));

  dcr_row_seq #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .base(base_addr), .step(stride),
    .rows_m1(rows_m1), .rd_en(rd_en), .rd_addr(rd_addr), .rd_last(rd_last)
  );

  // Command registers, held for the whole run.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      off_a_q <= '0;
      off_b_q <= '0;
      pair_q  <= 1'b0;
      large_q <= 1'b0;
      clr_en  <= 1'b0;
      clr_sel <= 2'b00;
    end else begin
      clr_en <= accept;
      if (accept) begin
        busy    <= 1'b1;
        off_a_q <= off_a_c;
        off_b_q <= off_b_c;
        pair_q  <= shape_is_pair(blk_mode);
        large_q <= shape_is_large(blk_mode);
        clr_sel <= {shape_is_pair(blk_mode), 1'b1};
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  // Per-lane add and saturate on the returned prediction row.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [OFF_W-1:0] lane_off;
    assign lane_off = (pair_q && g >= HALF) ? off_b_q : off_a_q;
    dcr_lane_clip #(.PIX_W(PIX_W), .OFF_W(OFF_W)) u_clip (
      .pred(rd_data[g*PIX_W +: PIX_W]),
      .off (lane_off),
      .pix (row_out[g*PIX_W +: PIX_W])
    );
  end

  // Stage aligned with the store's read latency, then the registered write.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_addr  <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_mask  <= '0;
      done     <= 1'b0;
    end else begin
      s1_valid <= rd_en;
      s1_last  <= rd_last;
      s1_addr  <= rd_addr;
      wr_en    <= s1_valid;
      done     <= s1_valid && s1_last;
      if (s1_valid) begin
        wr_addr <= s1_addr;
        wr_data <= row_out;
        wr_mask <= (pair_q || large_q) ? '1 : MASK_LO;
      end
    end
  end
endmodule

// File: rtl/dcr_recon_chk.sv
module dcr_recon_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic rd_en,
  input logic wr_en,
  input logic clr_en
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_accept_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_clr_follows_accept_R5: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> $past(start && !busy));
  assert_clr_single_R5: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !clr_en);
  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en, 2));
  assert_read_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> !clr_en);
endmodule

bind dc_recon_adder dcr_recon_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .rd_en(rd_en), .wr_en(wr_en), .clr_en(clr_en)
);

// File: tb/tb_dc_recon_adder.sv
module tb_dc_recon_adder;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int PIX_W = 10;
  localparam int ROWW  = LANES * PIX_W;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] blk_mode = 2'b00;
  logic [31:0] dc_a = '0, dc_b = '0;
  logic [9:0] base_addr = '0, stride = '0;
  logic busy, done, rd_en, wr_en, clr_en;
  logic [9:0] rd_addr, wr_addr;
  logic [ROWW-1:0] rd_data, wr_data;
  logic [LANES-1:0] wr_mask;
  logic [1:0] clr_sel;

  logic pre_en = 1'b0;
  logic [5:0] pre_row = '0;
  logic [ROWW-1:0] pre_data = '0;
  logic mon_clr = 1'b0;

  logic [ROWW-1:0] mem [DEPTH];
  logic [ROWW-1:0] expm [DEPTH];
  int clr_cnt, wr_cnt;
  logic [1:0] clr_seen;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_recon_adder dut (
    .clk(clk), .rst(rst), .start(start), .blk_mode(blk_mode), .dc_a(dc_a), .dc_b(dc_b),
    .base_addr(base_addr), .stride(stride), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .clr_en(clr_en), .clr_sel(clr_sel)
  );

  // Pixel store model: one-cycle registered read, lane-masked write.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr[5:0]];
    if (pre_en) mem[pre_row] <= pre_data;
    if (wr_en)
      for (int l = 0; l < LANES; l++)
        if (wr_mask[l]) mem[wr_addr[5:0]][l*PIX_W +: PIX_W] <= wr_data[l*PIX_W +: PIX_W];
  end

  always_ff @(posedge clk) begin
    if (mon_clr) begin
      clr_cnt <= 0; wr_cnt <= 0; clr_seen <= 2'b00;
    end else begin
      if (clr_en) begin clr_cnt <= clr_cnt + 1; clr_seen <= clr_sel; end
      if (wr_en) wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [PIX_W-1:0] recon(input logic [PIX_W-1:0] p, input int dc);
    longint o, s;
    o = (longint'(dc) + 32) >>> 6;
    s = longint'(p) + o;
    if (s < 0) return '0;
    if (s > 1023) return 10'd1023;
    return s[PIX_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_blk(input logic [1:0] m, input int dca, input int dcb,
                         input int base, input int strd, input bit poke);
    int n, cyc;
    bit busy_ok;
    for (int r = 0; r < DEPTH; r++) begin
      logic [ROWW-1:0] row;
      for (int l = 0; l < LANES; l++) row[l*PIX_W +: PIX_W] = PIX_W'($urandom % 1024);
      if (r % 9 == 0) row[0 +: PIX_W] = 10'd0;
      if (r % 7 == 0) row[PIX_W +: PIX_W] = 10'd1023;
      expm[r] = row;
      pre_en = 1'b1; pre_row = 6'(r); pre_data = row;
      @(negedge clk);
    end
    pre_en = 1'b0;
    mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
    n = m[1] ? 8 : 4;
    for (int r = 0; r < n; r++) begin
      int a;
      a = (base + r * strd) % DEPTH;
      for (int l = 0; l < LANES; l++) begin
        if (m[1] || l < 4)
          expm[a][l*PIX_W +: PIX_W] = recon(expm[a][l*PIX_W +: PIX_W], dca);
        else if (m == 2'b01)
          expm[a][l*PIX_W +: PIX_W] = recon(expm[a][l*PIX_W +: PIX_W], dcb);
      end
    end
    blk_mode = m; dc_a = dca; dc_b = dcb;
    base_addr = 10'(base); stride = 10'(strd); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; busy_ok = 1;
    while (!done && cyc < 100) begin
      if (!busy) busy_ok = 0;
      if (poke && cyc == 2) begin
        start = 1'b1; blk_mode = ~m; dc_a = ~dca; dc_b = ~dcb; base_addr = 10'd40;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == n + 2, "R7 done latency", cyc, n + 2);
    chk(busy_ok && busy, "R7 busy held through done", busy_ok && busy, 1);
    @(negedge clk);
    chk(!busy, "R7 busy low after done", busy, 0);
    chk(clr_cnt == 1, poke ? "R5 R8 clear strobe count" : "R5 clear strobe count", clr_cnt, 1);
    chk(clr_seen == ((m == 2'b01) ? 2'b11 : 2'b01), "R5 clear select", clr_seen,
        (m == 2'b01) ? 3 : 1);
    chk(wr_cnt == n, poke ? "R3 R8 row write count" : "R3 R4 row write count", wr_cnt, n);
    for (int r = 0; r < DEPTH; r++)
      for (int l = 0; l < LANES; l++)
        chk(mem[r][l*PIX_W +: PIX_W] == expm[r][l*PIX_W +: PIX_W],
            $sformatf("R1 R2 R3 R4 R6 R9 pixel row %0d lane %0d", r, l),
            mem[r][l*PIX_W +: PIX_W], expm[r][l*PIX_W +: PIX_W]);
  endtask

  function automatic int pick_dc();
    case ($urandom % 3)
      0: return int'($urandom);
      1: return int'($urandom % 131072) - 65536;
      default: return int'($urandom % 256) - 128;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd777));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !rd_en && !wr_en && !clr_en, "R7 reset state",
        {busy, done, rd_en, wr_en, clr_en}, 0);
    @(negedge clk);
    // Directed corners
    run_blk(2'b00, 0, 0, 3, 1, 0);                          // R1 zero offset
    run_blk(2'b00, 31, 0, 0, 2, 0);                         // R1 rounds to 0
    run_blk(2'b00, -33, 0, 5, 3, 0);                        // R1 floor to -1
    run_blk(2'b10, 32'h7FFFFFFF, 0, 1, 6, 0);               // R2 saturate high
    run_blk(2'b11, 32'h80000000, 0, 2, 5, 0);               // R2 saturate low
    run_blk(2'b01, 32'h7FFFFFFF, 32'h80000000, 7, 4, 0);    // R3 pair halves
    run_blk(2'b01, -96, 4000, 10, 1, 0);                    // R3 pair offsets
    run_blk(2'b10, 64 * 1024, -64 * 1023, 0, 1, 1);         // R8 start while busy
    run_blk(2'b00, -1, 0, 12, 5, 1);                        // R8 on short block
    for (int i = 0; i < 20; i++)
      run_blk(2'($urandom % 4), pick_dc(), pick_dc(), int'($urandom % 16),
              int'($urandom % 6) + 1, ($urandom % 4) == 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule